// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block gathers up to 32 peripheral interrupt inputs. Each input is brought into the local clock domain and then judged against its own trigger setting: level-high, level-low, rising edge or falling edge. Edge events are held in a sticky flag until software clears them. An input that passes its trigger test and is enabled takes part in routing. An 8-bit route setting per input names the cores it is delivered to and the parent interrupt lines it raises on each of those cores.

Software reaches every setting over a small register bus. The bus has a byte address, 32-bit write data, a write enable, four byte-lane strobes and a combinational read port. Enables are never written directly: one location sets enable bits and another clears them, so two agents can change different sources without a read-modify-write. The outputs are a pending vector for each core and a set of parent lines for each core. To put the block in a safe state, software writes all ones to the clear location and zero to the trigger-mode location.

Top module: `lic_top`

## Requirements
- R1: After reset all enables, route bytes, polarity bits and trigger-mode bits read as 0, the status word reads 0, and every pending and parent output is 0.
- R2: The route setting of source n is the byte at offset n (0x00 to 0x1F, little-endian within each 32-bit word). Bits [3:0] select cores 0 to 3 and bits [7:4] select parent lines 0 to 3. Each byte strobe updates only its own byte, so a full-strobe word write updates four consecutive sources and a write with no strobes changes nothing.
- R3: Writing to offset 0x28 sets every enable bit written as 1 and leaves the bits written as 0 unchanged.
- R4: Writing to offset 0x2C clears every enable bit written as 1 and leaves the bits written as 0 unchanged. Writing all ones disables every source.
- R5: The enable vector reads back at 0x24, the polarity word reads back at 0x30 and the trigger-mode word (1 = edge) reads back at 0x34.
- R6: A source in level mode (mode bit 0) is active while its input equals its polarity bit (1 = high, 0 = low). A change on the input reaches the status word after exactly two clock edges.
- R7: A source in edge mode (mode bit 1) latches a pending flag on a rising input edge when polarity is 1, or on a falling input edge when polarity is 0. The flag shows in the status word three clock edges after the input changes, stays set after the input returns, and ignores the opposite edge.
- R8: Writing 1s to the status offset 0x40 clears the latched flags of those sources. The same write has no effect on a level-mode source.
- R9: The status word at 0x40 is the trigger result ANDed with the enable vector. A disabled source appears in no status, pending or parent output.
- R10: Bit s of the pending vector of core c is set when source s is active, enabled and has route bit c set. A source whose route has no core bit reaches no core.
- R11: Parent line k of core c is asserted when at least one source that is pending on core c has route bit 4+k set.
- R12: Clearing a source's trigger-mode bit discards its latched edge flag, so returning to edge mode starts with no pending edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_irq | input | N_SRC (32) | Raw peripheral interrupt inputs, asynchronous |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | ADDR_W (8) | Byte address; bits [1:0] are ignored |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational register read data |
| core_pend | output | N_CORE*N_SRC (128) | Pending vector per core; core c occupies bits [c*N_SRC +: N_SRC] |
| parent_irq | output | N_CORE*N_PARENT (16) | Parent lines per core; line k of core c is bit c*N_PARENT+k |

## Verification
The bench builds the block with its default parameters: 32 sources, four cores, four parent lines, an 8-bit address and a two-stage synchroniser. With 32 sources, all eight route words and every byte lane are decoded. With four cores and four parent lines, every bit of a route byte has a meaning, so one source can be sent to all cores at once, or given parent bits with no core bit. The two-stage synchroniser fixes the level latency at two edges and the edge latency at three, and the directed scenarios sample at exactly those edges.

// File: rtl/lic_pkg.sv
package lic_pkg;

   localparam int unsigned BUS_W = 32;

   localparam logic [7:0] OFF_EN_VIEW = 8'h24;
   localparam logic [7:0] OFF_EN_SET  = 8'h28;
   localparam logic [7:0] OFF_EN_CLR  = 8'h2C;
   localparam logic [7:0] OFF_POL     = 8'h30;
   localparam logic [7:0] OFF_MODE    = 8'h34;
   localparam logic [7:0] OFF_STATUS  = 8'h40;

   typedef struct packed {
      logic [3:0] parent_sel;
      logic [3:0] core_sel;
   } route_t;

   typedef enum logic [1:0] {
      TRG_LVL_LOW  = 2'b00,
      TRG_LVL_HIGH = 2'b01,
      TRG_FALL     = 2'b10,
      TRG_RISE     = 2'b11
   } trig_mode_e;

   function automatic logic [BUS_W-1:0] lane_mask(input logic [3:0] be);
      logic [BUS_W-1:0] m;
      for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
      return m;
   endfunction

endpackage

// File: rtl/lic_sync.sv
module lic_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) chain[i] <= '0;
      end else begin
         chain[0] <= d_async;
         for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
      end
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/lic_trigger.sv
module lic_trigger
   import lic_pkg::*;
#(
   parameter int unsigned N_SRC = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] level_in,
   input  logic [N_SRC-1:0] pol,
   input  logic [N_SRC-1:0] edge_mode,
   input  logic [N_SRC-1:0] clr,
   output logic [N_SRC-1:0] trig
);

   logic [N_SRC-1:0] prev_q;
   logic [N_SRC-1:0] flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level_in;
   end

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      trig_mode_e mode;
      logic       hit;

      assign mode = trig_mode_e'({edge_mode[s], pol[s]});

      always_comb begin
         unique case (mode)
            TRG_RISE: hit = level_in[s] & ~prev_q[s];
            TRG_FALL: hit = ~level_in[s] & prev_q[s];
            default:  hit = 1'b0;
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              flag_q[s] <= 1'b0;
         else if (!edge_mode[s])  flag_q[s] <= 1'b0;
         else if (hit)            flag_q[s] <= 1'b1;
         else if (clr[s])         flag_q[s] <= 1'b0;
      end

      always_comb begin
         unique case (mode)
            TRG_LVL_HIGH: trig[s] = level_in[s];
            TRG_LVL_LOW:  trig[s] = ~level_in[s];
            default:      trig[s] = flag_q[s];
         endcase
      end
   end

endmodule

// File: rtl/lic_regs.sv
module lic_regs
   import lic_pkg::*;
#(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [3:0]         bus_be,
   input  logic [BUS_W-1:0]   bus_wdata,
   output logic [BUS_W-1:0]   bus_rdata,
   input  logic [N_SRC-1:0]   status,
   output logic [8*N_SRC-1:0] route_flat,
   output logic [N_SRC-1:0]   en_q,
   output logic [N_SRC-1:0]   pol_q,
   output logic [N_SRC-1:0]   mode_q,
   output logic [N_SRC-1:0]   clr
);

   localparam int unsigned WA_W = ADDR_W - 2;
   localparam int unsigned N_RW = N_SRC / 4;
   localparam logic [WA_W-1:0] W_EN_VIEW = WA_W'(OFF_EN_VIEW >> 2);
   localparam logic [WA_W-1:0] W_EN_SET  = WA_W'(OFF_EN_SET >> 2);
   localparam logic [WA_W-1:0] W_EN_CLR  = WA_W'(OFF_EN_CLR >> 2);
   localparam logic [WA_W-1:0] W_POL     = WA_W'(OFF_POL >> 2);
   localparam logic [WA_W-1:0] W_MODE    = WA_W'(OFF_MODE >> 2);
   localparam logic [WA_W-1:0] W_STATUS  = WA_W'(OFF_STATUS >> 2);

   logic [WA_W-1:0]  word;
   logic [N_SRC-1:0] wbits;
   logic             unused_lsb;

   assign word       = bus_addr[ADDR_W-1:2];
   assign wbits      = bus_wdata[N_SRC-1:0] & lane_mask(bus_be)[N_SRC-1:0];
   assign unused_lsb = ^bus_addr[1:0];

   assign clr = (bus_we && word == W_STATUS) ? wbits : '0;

   for (genvar w = 0; w < N_RW; w++) begin : g_rword
      for (genvar b = 0; b < 4; b++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               route_flat[32*w+8*b +: 8] <= '0;
            else if (bus_we && bus_be[b] && word == WA_W'(w))
               route_flat[32*w+8*b +: 8] <= bus_wdata[8*b +: 8];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         pol_q  <= '0;
         mode_q <= '0;
      end else if (bus_we) begin
         if (word == W_EN_SET) en_q   <= en_q | wbits;
         if (word == W_EN_CLR) en_q   <= en_q & ~wbits;
         if (word == W_POL)    pol_q  <= (pol_q & ~lane_mask(bus_be)[N_SRC-1:0]) | wbits;
         if (word == W_MODE)   mode_q <= (mode_q & ~lane_mask(bus_be)[N_SRC-1:0]) | wbits;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (int'(word) < int'(N_RW))
         bus_rdata = route_flat[32*int'(word) +: 32];
      else if (word == W_EN_VIEW)
         bus_rdata[N_SRC-1:0] = en_q;
      else if (word == W_POL)
         bus_rdata[N_SRC-1:0] = pol_q;
      else if (word == W_MODE)
         bus_rdata[N_SRC-1:0] = mode_q;
      else if (word == W_STATUS)
         bus_rdata[N_SRC-1:0] = status;
   end

endmodule

// File: rtl/lic_route.sv
module lic_route #(
   parameter int unsigned N_SRC    = 32,
   parameter int unsigned N_CORE   = 4,
   parameter int unsigned N_PARENT = 4
) (
   input  logic [N_SRC-1:0]          active,
   input  logic [8*N_SRC-1:0]        route_flat,
   output logic [N_CORE*N_SRC-1:0]   core_pend,
   output logic [N_CORE*N_PARENT-1:0] parent_irq
);

   logic [N_SRC-1:0] parent_sel [N_PARENT];
   logic [N_SRC-1:0] core_sel   [N_CORE];

   for (genvar s = 0; s < N_SRC; s++) begin : g_split
      for (genvar k = 0; k < N_PARENT; k++) begin : g_p
         assign parent_sel[k][s] = route_flat[8*s+4+k];
      end
      for (genvar c = 0; c < N_CORE; c++) begin : g_c
         assign core_sel[c][s] = route_flat[8*s+c];
      end
   end

   if (N_CORE < 4 || N_PARENT < 4) begin : g_spare
      logic unused_route;
      assign unused_route = ^route_flat;
   end

   for (genvar c = 0; c < N_CORE; c++) begin : g_core
      logic [N_SRC-1:0] hits;
      assign hits = active & core_sel[c];
      assign core_pend[c*N_SRC +: N_SRC] = hits;
      for (genvar k = 0; k < N_PARENT; k++) begin : g_line
         assign parent_irq[c*N_PARENT+k] = |(hits & parent_sel[k]);
      end
   end

endmodule

// File: rtl/lic_top.sv
module lic_top
   import lic_pkg::*;
#(
   parameter int unsigned N_SRC       = 32,
   parameter int unsigned N_CORE      = 4,
   parameter int unsigned N_PARENT    = 4,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_SRC-1:0]           src_irq,
   input  logic                       bus_we,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [3:0]                 bus_be,
   input  logic [31:0]                bus_wdata,
   output logic [31:0]                bus_rdata,
   output logic [N_CORE*N_SRC-1:0]    core_pend,
   output logic [N_CORE*N_PARENT-1:0] parent_irq
);

   if (N_SRC < 4 || N_SRC > 32 || (N_SRC % 4) != 0) begin : g_bad_src
      $error("lic_top: N_SRC must be a multiple of 4 in 4..32");
   end
   if (N_CORE < 1 || N_CORE > 4) begin : g_bad_core
      $error("lic_top: N_CORE must be 1..4");
   end
   if (N_PARENT < 1 || N_PARENT > 4) begin : g_bad_parent
      $error("lic_top: N_PARENT must be 1..4");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("lic_top: ADDR_W must reach offset 0x40");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lic_top: SYNC_STAGES must be at least 2");
   end

   logic [N_SRC-1:0]   level_in;
   logic [N_SRC-1:0]   trig;
   logic [N_SRC-1:0]   active;
   logic [N_SRC-1:0]   en_view;
   logic [N_SRC-1:0]   pol_q;
   logic [N_SRC-1:0]   mode_q;
   logic [N_SRC-1:0]   clr;
   logic [8*N_SRC-1:0] route_flat;

   lic_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (src_irq),
      .q_sync  (level_in)
   );

   lic_trigger #(.N_SRC(N_SRC)) u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .level_in  (level_in),
      .pol       (pol_q),
      .edge_mode (mode_q),
      .clr       (clr),
      .trig      (trig)
   );

   assign active = trig & en_view;

   lic_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_be     (bus_be),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .status     (active),
      .route_flat (route_flat),
      .en_q       (en_view),
      .pol_q      (pol_q),
      .mode_q     (mode_q),
      .clr        (clr)
   );

   lic_route #(.N_SRC(N_SRC), .N_CORE(N_CORE), .N_PARENT(N_PARENT)) u_route (
      .active     (active),
      .route_flat (route_flat),
      .core_pend  (core_pend),
      .parent_irq (parent_irq)
   );

endmodule

// File: rtl/lic_checker.sv
module lic_checker
   import lic_pkg::*;
#(
   parameter int unsigned N_SRC    = 32,
   parameter int unsigned N_CORE   = 4,
   parameter int unsigned N_PARENT = 4,
   parameter int unsigned ADDR_W   = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bus_we,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic [3:0]                 bus_be,
   input logic [31:0]                bus_wdata,
   input logic [N_SRC-1:0]           en_view,
   input logic [8*N_SRC-1:0]         route_flat,
   input logic [N_CORE*N_SRC-1:0]    core_pend,
   input logic [N_CORE*N_PARENT-1:0] parent_irq
);

   logic set_full;
   logic clr_full;
   assign set_full = bus_we && bus_be == 4'hF && bus_addr == ADDR_W'(OFF_EN_SET);
   assign clr_full = bus_we && bus_be == 4'hF && bus_addr == ADDR_W'(OFF_EN_CLR);

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (core_pend == '0 && parent_irq == '0));

   p_route_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we || bus_be == 4'h0) |=> $stable(route_flat));

   p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set_full |=> ((en_view & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

   p_en_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_full |=> ((en_view & $past(bus_wdata[N_SRC-1:0])) == '0));

   for (genvar c = 0; c < N_CORE; c++) begin : g_core
      p_pend_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (core_pend[c*N_SRC +: N_SRC] & ~en_view) == '0);
      for (genvar k = 0; k < N_PARENT; k++) begin : g_line
         p_parent_needs_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
            parent_irq[c*N_PARENT+k] |-> (core_pend[c*N_SRC +: N_SRC] != '0));
      end
   end

endmodule

bind lic_top lic_checker #(
   .N_SRC(N_SRC), .N_CORE(N_CORE), .N_PARENT(N_PARENT), .ADDR_W(ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .bus_be     (bus_be),
   .bus_wdata  (bus_wdata),
   .en_view    (en_view),
   .route_flat (route_flat),
   .core_pend  (core_pend),
   .parent_irq (parent_irq)
);

// File: tb/tb_lic_top.sv
`timescale 1ns/1ps
module tb_lic_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [31:0]  src_irq = '0;
   logic         bus_we = 1'b0;
   logic [7:0]   bus_addr = '0;
   logic [3:0]   bus_be = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [127:0] core_pend;
   logic [15:0]  parent_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   lic_top dut (
      .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .core_pend(core_pend), .parent_irq(parent_irq)
   );

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_we = 1'b0; bus_be = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(8'h24, v); chk("R1 enable", v, 0);
      rd(8'h30, v); chk("R1 polarity", v, 0);
      rd(8'h34, v); chk("R1 mode", v, 0);
      rd(8'h40, v); chk("R1 status", v, 0);
      rd(8'h1C, v); chk("R1 route", v, 0);
      chk("R1 pend", core_pend, 0);
      chk("R1 parent", parent_irq, 0);
   endtask

   task automatic t_route_access();
      logic [31:0] v;
      wr(8'h00, 32'h8421F012, 4'hF);
      rd(8'h00, v); chk("R2 word write", v, 32'h8421F012);
      wr(8'h04, 32'h11223344, 4'hF);
      wr(8'h04, 32'hEEABEEEE, 4'b0100);
      rd(8'h04, v); chk("R2 byte strobe", v, 32'h11AB3344);
      wr(8'h04, 32'hFFFFFFFF, 4'b0000);
      rd(8'h04, v); chk("R2 no strobe", v, 32'h11AB3344);
   endtask

   task automatic t_enables();
      logic [31:0] v;
      wr(8'h28, 32'h000000FF, 4'hF);
      rd(8'h24, v); chk("R3 set", v, 32'h000000FF);
      wr(8'h28, 32'h00000100, 4'hF);
      rd(8'h24, v); chk("R3 zeros keep", v, 32'h000001FF);
      wr(8'h2C, 32'h0000000F, 4'hF);
      rd(8'h24, v); chk("R4 clear some", v, 32'h000001F0);
      wr(8'h2C, 32'hFFFFFFFF, 4'hF);
      rd(8'h24, v); chk("R4 clear all", v, 0);
      wr(8'h30, 32'hA5A55A5A, 4'hF);
      rd(8'h30, v); chk("R5 polarity", v, 32'hA5A55A5A);
      wr(8'h34, 32'h3C3CC3C3, 4'hF);
      rd(8'h34, v); chk("R5 mode", v, 32'h3C3CC3C3);
      wr(8'h34, 32'h0, 4'hF);
      wr(8'h30, 32'h0, 4'hF);
   endtask

   task automatic t_level_route();
      logic [31:0] v;
      wr(8'h00, 32'h21000000, 4'b1000);
      wr(8'h30, 32'h00000008, 4'hF);
      wr(8'h28, 32'h00000008, 4'hF);
      rd(8'h40, v); chk("R6 high idle", v, 0);
      src_irq[3] = 1'b1;
      waitn(1); rd(8'h40, v); chk("R6 latency one edge", v, 0);
      waitn(1); rd(8'h40, v); chk("R6 level high", v, 32'h8);
      chk("R10 core0 only", core_pend, 128'h8);
      chk("R11 core0 line1", parent_irq, 16'h0002);
      wr(8'h30, 32'h0, 4'hF);
      rd(8'h40, v); chk("R6 level low inactive", v, 0);
      src_irq[3] = 1'b0;
      waitn(2); rd(8'h40, v); chk("R6 level low active", v, 32'h8);
      wr(8'h00, 32'h2F000000, 4'b1000);
      chk("R10 broadcast", core_pend,
          (128'h1 << 3) | (128'h1 << 35) | (128'h1 << 67) | (128'h1 << 99));
      chk("R11 broadcast lines", parent_irq, 16'h2222);
      wr(8'h00, 32'hF0000000, 4'b1000);
      chk("R10 no core bit", core_pend, 0);
      chk("R11 no core bit", parent_irq, 0);
      wr(8'h00, 32'h21000000, 4'b1000);
      wr(8'h2C, 32'h00000008, 4'hF);
      rd(8'h40, v); chk("R9 masked status", v, 0);
      chk("R9 masked pend", core_pend, 0);
      chk("R9 masked parent", parent_irq, 0);
   endtask

   task automatic t_edge();
      logic [31:0] v;
      wr(8'h04, 32'h84000000, 4'b1000);
      wr(8'h34, 32'h00000080, 4'hF);
      wr(8'h30, 32'h00000080, 4'hF);
      wr(8'h28, 32'h00000080, 4'hF);
      rd(8'h40, v); chk("R7 idle", v, 0);
      src_irq[7] = 1'b1;
      waitn(2); rd(8'h40, v); chk("R7 not yet", v, 0);
      waitn(1); rd(8'h40, v); chk("R7 rise latched", v, 32'h80);
      chk("R10 core2", core_pend, 128'h1 << 71);
      chk("R11 core2 line3", parent_irq, 16'h0800);
      src_irq[7] = 1'b0;
      waitn(3); rd(8'h40, v); chk("R7 sticky", v, 32'h80);
      wr(8'h40, 32'h00000080, 4'hF);
      rd(8'h40, v); chk("R8 w1c", v, 0);
      wr(8'h30, 32'h0, 4'hF);
      src_irq[7] = 1'b1;
      waitn(4); rd(8'h40, v); chk("R7 falling ignores rise", v, 0);
      src_irq[7] = 1'b0;
      waitn(2); rd(8'h40, v); chk("R7 fall not yet", v, 0);
      waitn(1); rd(8'h40, v); chk("R7 fall latched", v, 32'h80);
      wr(8'h28, 32'h00000008, 4'hF);
      rd(8'h40, v); chk("R8 level plus edge", v, 32'h88);
      wr(8'h40, 32'h00000008, 4'hF);
      rd(8'h40, v); chk("R8 level unaffected", v, 32'h88);
      wr(8'h34, 32'h0, 4'hF);
      wr(8'h30, 32'h00000088, 4'hF);
      rd(8'h40, v); chk("R12 level now idle", v, 0);
      wr(8'h34, 32'h00000080, 4'hF);
      rd(8'h40, v); chk("R12 flag discarded", v, 0);
      chk("R12 no parent", parent_irq, 0);
   endtask

   initial begin
      waitn(3);
      rst_n = 1'b1;
      waitn(1);
      t_reset();
      t_route_access();
      t_enables();
      t_level_route();
      t_edge();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule